// File: doc/BRIEF.md
# Programmable two-stage calendar tick divider

This block turns a free-running calendar source clock into the once-per-second enable that advances a calendar. Two programmable counters are cascaded. The first stage divides the source by `div_a + 1` and raises a one-cycle enable at that intermediate rate. The second stage counts those enables and divides them by `div_s + 1`. The tick rate is therefore f_src / ((div_a + 1) * (div_s + 1)). A large first-stage value keeps the second stage, which is wider, toggling less often and so saves power.

Both divide values share one 32-bit configuration word on a simple write port. The word can only change while the initialisation input is high. While that input is high the counters are held at zero and both enables stay low. The count starts afresh from zero when the input falls.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset the configuration word reads 0x007F00FF. This is div_a = 127 in bits 22:16 and div_s = 255 in bits 14:0, which gives one tick per 32768 source cycles.
- R2: A write with `init_mode_i` high loads div_s from bits 14:0 and div_a from bits 22:16 of `reg_wdata_i`. All other bits are dropped and read back as zero.
- R3: A write with `init_mode_i` low has no effect: the readback and the divide timing stay unchanged.
- R4: While running, `ck_apre_o` is a one-cycle pulse in every (div_a+1)-th cycle.
- R5: `tick_o` is a one-cycle pulse once every (div_a+1)*(div_s+1) running cycles, and it is only raised in a cycle where `ck_apre_o` is also high.
- R6: While `init_mode_i` is high, `ck_apre_o` and `tick_o` are both low.
- R7: Both counters restart from zero when `init_mode_i` falls. The first cycle with `init_mode_i` low counts as running cycle 0. The first `ck_apre_o` comes in running cycle div_a, and the first `tick_o` in running cycle (div_a+1)*(div_s+1)-1, whatever count was reached before.
- R8: With the reset values, the first tick comes in running cycle 32767.
- R9: div_a = 0 gives `ck_apre_o` in every running cycle. div_a = 0 with div_s = 0 gives `tick_o` in every running cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Calendar source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_mode_i | input | 1 | Initialisation mode: unlocks the word, holds the counters at zero |
| reg_we_i | input | 1 | Write strobe for the configuration word |
| reg_wdata_i | input | 32 | Write data for the configuration word |
| reg_rdata_o | output | 32 | Current configuration word |
| ck_apre_o | output | 1 | First-stage enable pulse |
| tick_o | output | 1 | Calendar tick pulse |

## Verification
The bench builds the block with its default widths of 7 and 15 bits and the default reset values. This puts one full 32768-cycle reset period within reach, so the first tick is checked at its exact cycle. The divide values that are programmed at run time then cover the extremes: zero in either stage, small products, and a restart partway through a period. A scoreboard predicts every first-stage pulse and every tick from the programmed values. It also confirms that a locked write changes neither the readback nor the pulse pattern.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned A_LSB     = 16;
  localparam int unsigned DEF_A_W   = 7;
  localparam int unsigned DEF_S_W   = 15;
  localparam int unsigned DEF_A_RST = 127;
  localparam int unsigned DEF_S_RST = 255;
endpackage

// File: rtl/presc_cfg_reg.sv
module presc_cfg_reg
  import rtc_presc_pkg::*;
#(
  parameter int unsigned A_W   = DEF_A_W,
  parameter int unsigned S_W   = DEF_S_W,
  parameter int unsigned A_RST = DEF_A_RST,
  parameter int unsigned S_RST = DEF_S_RST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_mode_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [A_W-1:0]   div_a_o,
  output logic [S_W-1:0]   div_s_o,
  output logic [REG_W-1:0] rdata_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_a_o <= A_W'(A_RST);
      div_s_o <= S_W'(S_RST);
    end else if (we_i && init_mode_i) begin
      div_a_o <= wdata_i[A_LSB +: A_W];
      div_s_o <= wdata_i[S_W-1:0];
    end
  end

  always_comb begin
    rdata_o                = '0;
    rdata_o[S_W-1:0]       = div_s_o;
    rdata_o[A_LSB +: A_W]  = div_a_o;
  end
endmodule

// File: rtl/presc_stage.sv
module presc_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && !clr_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (wrap_o)    cnt_q <= '0;
    else if (en_i)      cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_presc_pkg::*;
#(
  parameter int unsigned A_W   = DEF_A_W,
  parameter int unsigned S_W   = DEF_S_W,
  parameter int unsigned A_RST = DEF_A_RST,
  parameter int unsigned S_RST = DEF_S_RST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_mode_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             ck_apre_o,
  output logic             tick_o
);
  logic [A_W-1:0] div_a;
  logic [S_W-1:0] div_s;
  logic           run;

  assign run = !init_mode_i;

  presc_cfg_reg #(.A_W(A_W), .S_W(S_W), .A_RST(A_RST), .S_RST(S_RST)) u_cfg (
    .clk_i, .rst_ni, .init_mode_i,
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .div_a_o (div_a),
    .div_s_o (div_s),
    .rdata_o (reg_rdata_o)
  );

  // first stage runs on every source cycle, second on first-stage wraps
  presc_stage #(.W(A_W)) u_stage_a (
    .clk_i, .rst_ni,
    .clr_i   (init_mode_i),
    .en_i    (run),
    .limit_i (div_a),
    .wrap_o  (ck_apre_o)
  );

  presc_stage #(.W(S_W)) u_stage_s (
    .clk_i, .rst_ni,
    .clr_i   (init_mode_i),
    .en_i    (ck_apre_o),
    .limit_i (div_s),
    .wrap_o  (tick_o)
  );
endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk
  import rtc_presc_pkg::*;
#(
  parameter int unsigned A_W = DEF_A_W,
  parameter int unsigned S_W = DEF_S_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_mode_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             ck_apre_o,
  input logic             tick_o
);
  logic a_zero;
  assign a_zero = (reg_rdata_o[A_LSB +: A_W] == '0);

  a_r6_quiet_in_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_mode_i |-> (!ck_apre_o && !tick_o));

  a_r5_tick_with_apre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> ck_apre_o);

  a_r3_locked_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_mode_i |=> $stable(reg_rdata_o));

  a_r4_apre_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_apre_o && !a_zero) |=> !ck_apre_o);

  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(init_mode_i) && !a_zero) |-> !ck_apre_o);

  a_r2_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[REG_W-1:A_LSB+A_W] == '0) && (reg_rdata_o[A_LSB-1:S_W] == '0));
endmodule

bind rtc_prescaler rtc_prescaler_chk #(.A_W(A_W), .S_W(S_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_mode_i (init_mode_i),
  .reg_rdata_o (reg_rdata_o),
  .ck_apre_o   (ck_apre_o),
  .tick_o      (tick_o)
);

// File: tb/rtc_prescaler_test.sv
`timescale 1ns/1ps
module rtc_prescaler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_mode = 1'b1;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        apre, tick;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  int exp_apre[$];
  int exp_tick[$];

  rtc_prescaler uut (
    .clk_i(clk), .rst_ni(rst_n), .init_mode_i(init_mode),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ck_apre_o(apre), .tick_o(tick)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops predicted pulse cycles as pulses appear
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (apre) begin
        if (exp_apre.size() == 0) check("R4 unexpected ck_apre", cyc, -1);
        else check("R4 ck_apre cycle", cyc, exp_apre.pop_front());
      end
      if (tick) begin
        if (exp_tick.size() == 0) check("R5 unexpected tick", cyc, -1);
        else check("R5 tick cycle", cyc, exp_tick.pop_front());
      end
    end
  end

  task automatic write_word(input logic [31:0] v);
    @(posedge clk); #1;
    we = 1'b1; wdata = v;
    @(posedge clk); #1;
    we = 1'b0; wdata = '0;
  endtask

  // driver: leave init for len cycles, predicting every pulse
  task automatic run_seg(input int a, input int s, input int len, input bit bad_wr);
    int m;
    int p;
    p = (a + 1) * (s + 1);
    @(posedge clk); #1;
    init_mode = 1'b0;
    m = cyc;
    for (int t = a; t < len; t += a + 1) exp_apre.push_back(m + t);
    for (int t = p - 1; t < len; t += p) exp_tick.push_back(m + t);
    for (int i = 0; i < len; i++) begin
      if (bad_wr && i == len / 2) begin we = 1'b1; wdata = 32'hFFFF_FFFF; end
      @(posedge clk); #1;
      we = 1'b0; wdata = '0;
    end
    init_mode = 1'b1;
    check("R7 missed ck_apre pulses", exp_apre.size(), 0);
    check("R7 missed tick pulses", exp_tick.size(), 0);
    exp_apre.delete();
    exp_tick.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
    check("R1 reset word", rdata, 32'h007F_00FF);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R6 outputs low in init", {apre, tick}, 0);
    end
    // R8: reset divide values, first tick at running cycle 32767
    run_seg(127, 255, 32768 + 20, 1'b0);
    @(negedge clk);
    check("R6 outputs low after re-entering init", {apre, tick}, 0);
    // R2: field placement, spare bits dropped
    write_word(32'hFF83_8004);
    @(negedge clk);
    check("R2 spare bits dropped", rdata, 32'h0003_0004);
    // R3: write while running ignored, timing unchanged
    run_seg(3, 4, 100, 1'b1);
    @(negedge clk);
    check("R3 locked write ignored", rdata, 32'h0003_0004);
    // R7: restart partway through a period
    run_seg(3, 4, 7, 1'b0);
    run_seg(3, 4, 45, 1'b0);
    // R9: zero divide values
    write_word(32'h0000_0000);
    @(negedge clk);
    check("R2 zero word", rdata, 32'h0);
    run_seg(0, 0, 10, 1'b0);
    write_word(32'h0000_0005);
    run_seg(0, 5, 30, 1'b0);
    write_word(32'h0002_0000);
    run_seg(2, 0, 30, 1'b0);
    write_word(32'h007F_7FFF);
    @(negedge clk);
    check("R2 max word", rdata, 32'h007F_7FFF);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule